// File: doc/BRIEF.md
# Load/Store Pipeline Interlock

This block watches the instruction at the boundary between the register-fetch (RF) and execute (EX) stages of a five-stage in-order pipeline (IF, RF, EX, DC, WB). It raises a stall request for two reasons. The first is a load-use dependency: the instruction in RF reads a register that the load now in EX is still fetching. The second is a data-cache port conflict: a store keeps the cache busy during both its DC and its WB cycle, so a memory instruction directly behind it would reach DC while the port is still taken. Both hazards cost exactly one pipeline cycle.

The block keeps its own copy of the EX-stage descriptor. An instruction presented on the RF inputs moves into EX at a clock edge where neither stall nor flush is high. While the stall is high, the stages upstream of EX must hold their contents, so the RF inputs stay unchanged. At the next edge the block loads an invalid descriptor (a bubble) into EX and raises the bubble strobe for that cycle. Loads and stores retire in program order, so these two interlocks are the only ordering logic needed. A flush empties EX and blocks any stall from the flushed instruction.

Top module: `ldst_interlock`

## Requirements
- R1: After reset, EX holds no instruction, so stall and bubble are both 0 whatever is on the RF inputs.
- R2: stall is 1 in the same cycle when the valid RF instruction has a source register (source i on bits [5*i+4:5*i] of rfSrcs) equal to the nonzero destination of the valid load in EX.
- R3: A load whose destination is register 0 never causes a load-use stall.
- R4: stall is 1 when a valid store is in EX and the valid RF instruction is a load or a store, whatever registers are involved.
- R5: No stall occurs when the RF instruction is not a memory instruction behind a store, when it has no matching register behind a load, when EX holds neither a load nor a store, or when either instruction is invalid.
- R6: At the edge that ends a cycle with stall high, a bubble enters EX, and bubble is 1 for exactly that next cycle.
- R7: Each hazard stalls for exactly one cycle. After the stall, the held RF instruction goes into EX, and it then acts as a hazard source for the instruction behind it.
- R8: When flush is 1, stall is 0 in that cycle. EX is emptied at the next edge, so the following cycle shows neither stall nor bubble from earlier contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard the RF instruction and empty EX |
| rfValid | input | 1 | RF instruction is valid |
| rfLoad | input | 1 | RF instruction is a load |
| rfStore | input | 1 | RF instruction is a store |
| rfDest | input | 5 | RF instruction destination register |
| rfSrcs | input | 10 | RF source registers, source i on bits [5*i+4:5*i] |
| stall | output | 1 | Hold IF/RF this cycle and insert a bubble into EX |
| bubble | output | 1 | EX holds an injected bubble this cycle |

## Verification
The bench targets several corner cases. A match on the second source field catches a design that compares only one field. A load to register 0 followed by a reader of register 0 catches a design that treats register 0 as a real dependency. A store followed by a memory instruction with no shared register catches an interlock that keeps only the register check. The cycle after each stall is checked for a repeat stall, which a design that fails to clear the EX copy would raise. The cycle after that is checked to confirm that the released load blocks its own dependent. A flush in the same cycle as a hazard, and just before one, must suppress the stall and the bubble; a design that ignores flush would stall on a discarded instruction.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  parameter int REG_AW  = 5;
  parameter int NUM_SRC = 2;

  typedef struct packed {
    logic                           valid;
    logic                           load;
    logic                           store;
    logic [REG_AW-1:0]              dest;
    logic [NUM_SRC-1:0][REG_AW-1:0] srcs;
  } instDesc_t;

  typedef struct packed {
    logic stall;     // hold upstream, bubble into EX
    logic kill;      // flush: empty EX
    logic loadUse;   // reason: load-use dependency
    logic portBusy;  // reason: store holds cache port
  } ctrlStrobe_t;
endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  instDesc_t   rfDesc,
  input  instDesc_t   exDesc,
  output ctrlStrobe_t strobes
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0] srcHit;
  logic exLoadLive, rfMem, loadUse, portBusy;

  assign exLoadLive = exDesc.valid && exDesc.load && (exDesc.dest != ZERO_REG);
  assign rfMem      = rfDesc.load || rfDesc.store;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign srcHit[i] = (rfDesc.srcs[i] == exDesc.dest);
  end

  assign loadUse  = rfDesc.valid && exLoadLive && (|srcHit);
  assign portBusy = rfDesc.valid && exDesc.valid && exDesc.store && rfMem;

  always_comb begin
    strobes          = '0;
    strobes.kill     = flush;
    strobes.loadUse  = loadUse && !flush;
    strobes.portBusy = portBusy && !flush;
    strobes.stall    = (loadUse || portBusy) && !flush;
  end

  // R3: a load to register 0 never stalls a non-memory follower
  p_zero_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exDesc.load && !exDesc.store && exDesc.dest == ZERO_REG && !rfMem) |-> !strobes.stall);

  // R5: nothing in EX means nothing to wait for
  p_idle_ex_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !exDesc.valid |-> !strobes.stall);

  // R5: an invalid RF slot never stalls
  p_idle_rf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rfDesc.valid |-> !strobes.stall);
endmodule

// File: rtl/ldst_dp.sv
module ldst_dp
  import ldst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  instDesc_t   rfDesc,
  input  ctrlStrobe_t strobes,
  output instDesc_t   exDesc,
  output logic        bubbleQ
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exDesc  <= '0;
      bubbleQ <= 1'b0;
    end else if (strobes.kill) begin
      exDesc  <= '0;
      bubbleQ <= 1'b0;
    end else if (strobes.stall) begin
      exDesc  <= '0;
      bubbleQ <= 1'b1;
    end else begin
      exDesc  <= rfDesc;
      bubbleQ <= 1'b0;
    end
  end

  // R6: every stall is followed by a bubble cycle
  p_stall_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.stall |=> bubbleQ);

  // R7: a bubble in EX cannot stall again
  p_single_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bubbleQ |-> !strobes.stall);

  // R8: after a flush, neither stall nor bubble
  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.kill |=> (!strobes.stall && !bubbleQ));
endmodule

// File: rtl/ldst_interlock.sv
module ldst_interlock
  import ldst_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      rfValid,
  input  logic                      rfLoad,
  input  logic                      rfStore,
  input  logic [REG_AW-1:0]         rfDest,
  input  logic [NUM_SRC*REG_AW-1:0] rfSrcs,
  output logic                      stall,
  output logic                      bubble
);
  instDesc_t   rfDesc, exDesc;
  ctrlStrobe_t strobes;

  always_comb begin
    rfDesc       = '0;
    rfDesc.valid = rfValid;
    rfDesc.load  = rfLoad;
    rfDesc.store = rfStore;
    rfDesc.dest  = rfDest;
    rfDesc.srcs  = rfSrcs;
  end

  ldst_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rfDesc(rfDesc), .exDesc(exDesc), .strobes(strobes)
  );

  ldst_dp u_dp (
    .clk(clk), .rst_n(rst_n), .rfDesc(rfDesc),
    .strobes(strobes), .exDesc(exDesc), .bubbleQ(bubble)
  );

  assign stall = strobes.stall;
endmodule

// File: tb/sim_ldst_interlock.sv
module sim_ldst_interlock;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic       rfValid = 1'b0, rfLoad = 1'b0, rfStore = 1'b0;
  logic [4:0] rfDest = '0;
  logic [9:0] rfSrcs = '0;
  logic       stall, bubble;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the EX slot
  logic       mV = 0, mL = 0, mS = 0, mB = 0;
  logic [4:0] mD = '0;

  always #(CLK_P/2) clk = ~clk;

  ldst_interlock u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rfValid(rfValid), .rfLoad(rfLoad), .rfStore(rfStore),
    .rfDest(rfDest), .rfSrcs(rfSrcs), .stall(stall), .bubble(bubble)
  );

  function automatic logic expStall();
    logic hit;
    hit = (rfSrcs[4:0] == mD) || (rfSrcs[9:5] == mD);
    if (flush || !rfValid || !mV) return 1'b0;
    if (mL && mD != 5'd0 && hit) return 1'b1;
    if (mS && (rfLoad || rfStore)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string tagOf();
    if (flush) return "R8";
    if (mB) return "R6";
    if (mL && mD == 5'd0) return "R3";
    if (mL && expStall()) return "R2";
    if (mS && expStall()) return "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, l, s, input logic [4:0] d, a, b, input logic f);
    rfValid = v; rfLoad = l; rfStore = s; rfDest = d; rfSrcs = {b, a}; flush = f;
  endtask

  // inputs already driven after a negedge; check, update model, cross posedge
  task automatic cycle(input string tag);
    logic es;
    #(CLK_P/4);
    es = expStall();
    check(tag, "stall", stall, es);
    check(tag, "bubble", bubble, mB);
    @(posedge clk);
    if (flush) begin mV = 0; mB = 0; end
    else if (es) begin mV = 0; mB = 1; end
    else begin mV = rfValid; mL = rfLoad; mS = rfStore; mD = rfDest; mB = 0; end
    @(negedge clk);
  endtask

  initial begin
    logic held;
    void'($urandom(32'd4242));
    @(negedge clk);
    drive(1, 1, 0, 5'd3, 5'd3, 5'd3, 0);
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    check("R1", "stall in reset", stall, 1'b0);
    check("R1", "bubble in reset", bubble, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0);
    cycle("R1");

    // R2 on source A, then R6 bubble / R7 released load
    drive(1, 1, 0, 5'd7, 5'd1, 5'd2, 0); cycle("R5");
    drive(1, 1, 0, 5'd9, 5'd7, 5'd0, 0); cycle("R2");
    cycle("R6");                          // held, must not stall again (R7)
    drive(1, 0, 0, 5'd4, 5'd2, 5'd9, 0); cycle("R7"); // depends on released load
    cycle("R6");
    // R2 on source B
    drive(1, 1, 0, 5'd5, 5'd0, 5'd0, 0); cycle("R5");
    drive(1, 0, 0, 5'd6, 5'd1, 5'd5, 0); cycle("R2");
    cycle("R6");
    // R3: load to r0, reader of r0
    drive(1, 1, 0, 5'd0, 5'd1, 5'd1, 0); cycle("R5");
    drive(1, 0, 0, 5'd6, 5'd0, 5'd0, 0); cycle("R3");
    // R4: store then load with no shared register
    drive(1, 0, 1, 5'd0, 5'd1, 5'd2, 0); cycle("R5");
    drive(1, 1, 0, 5'd8, 5'd3, 5'd4, 0); cycle("R4");
    cycle("R6");
    // R4: store then store; R5 store then ALU
    drive(1, 0, 1, 5'd0, 5'd1, 5'd2, 0); cycle("R5");
    drive(1, 0, 1, 5'd0, 5'd11, 5'd12, 0); cycle("R4");
    cycle("R6");
    drive(1, 0, 0, 5'd3, 5'd1, 5'd2, 0); cycle("R5");
    // R5: load then unrelated, invalid RF behind load
    drive(1, 1, 0, 5'd10, 5'd1, 5'd2, 0); cycle("R5");
    drive(0, 0, 0, 5'd0, 5'd10, 5'd10, 0); cycle("R5");
    // R8: flush on a hazard cycle, and flush just before one
    drive(1, 1, 0, 5'd12, 5'd1, 5'd2, 0); cycle("R5");
    drive(1, 0, 0, 5'd1, 5'd12, 5'd0, 1); cycle("R8");
    drive(1, 0, 0, 5'd1, 5'd12, 5'd0, 0); cycle("R8");
    drive(1, 0, 1, 5'd0, 5'd1, 5'd2, 1); cycle("R8");
    drive(1, 1, 0, 5'd3, 5'd1, 5'd2, 0); cycle("R8");

    // random mix over a small register set
    held = 0;
    for (int n = 0; n < 3000; n++) begin
      if (!held) begin
        logic [2:0] k;
        k = 3'($urandom_range(0, 7));
        drive(k != 0, k inside {3'd1, 3'd2, 3'd3}, k inside {3'd4, 3'd5},
              5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
              5'($urandom_range(0, 3)), 1'b0);
      end
      flush = ($urandom_range(0, 19) == 0);
      held = expStall();
      cycle(tagOf());
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule